// File: doc/BRIEF.md
# Parallel-Prefix Carry Lookahead Adder

This block adds two unsigned N-bit operands and a one-bit carry input. It returns an N-bit sum and a carry output. It does not pass a carry bit by bit along the word. Each bit position first forms a generate term (a AND b) and a propagate term (a OR b). A prefix network then merges adjacent groups, and the span of each group doubles from one level to the next.

The carry input enters the network as an extra element below bit 0. That element has generate equal to the carry input and propagate equal to zero. After the last level, element i holds the carry into bit i, and the top element holds the carry output. The number of levels is ceil(log2(N+1)), so the logic depth stays logarithmic up to a 64-bit word.

A parameter selects one of two forms. In the first, the result passes through one register stage to help timing closure. In the second, the adder is purely combinational.

Top module: `prefix_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the unsigned total `a + b + cin`.
- R2: `cout` equals bit WIDTH of that same total, which is the carry into the position just above the most significant bit.
- R3: With both operands zero and `cin` = 1, `sum` is 1 and `cout` is 0. This shows that the carry input reaches bit 0.
- R4: When `b` is the bitwise complement of `a`, every bit propagates. With `cin` = 0, `sum` is all ones and `cout` is 0. With `cin` = 1, `sum` is zero and `cout` is 1, because the carry input travels across the whole word.
- R5: With both operands all ones and `cin` = 1, `sum` is all ones and `cout` is 1.
- R6: When REGISTER_OUT = 1, the result of the operands present at a rising clock edge appears on the outputs just after that edge and holds for one cycle. When REGISTER_OUT = 0, the outputs follow the operands within the same cycle.
- R7: When REGISTER_OUT = 1 and the asynchronous active-low `rst_n` is low, `sum` and `cout` are zero, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry input |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry output |

## Verification
The bound checker runs on every clock. It aligns the operands with the output latency chosen by REGISTER_OUT. It then compares `sum` and `cout` with an arithmetic reference (R1, R2), and it checks the fixed responses for an injected carry, a full propagate chain and generate in every bit (R3, R4, R5).

Some behaviour only the bench's scenarios can show:
- the exact cycle in which a new result appears (R6);
- zero outputs under reset while the operands are nonzero (R7);
- complete coverage of every 8-bit operand pair with both carry-input values;
- 64-bit random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Group carry status: generate and propagate over a span of bits
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge an upper group with the adjacent lower group
    function automatic gp_t gp_merge(input gp_t upper, input gp_t lower);
        gp_t r;
        r.g = upper.g | (upper.p & lower.g);
        r.p = upper.p & lower.p;
        return r;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH:0]   g_elem,
    output logic [WIDTH:0]   p_elem
);
    // Element 0 is the carry input seen as a bit that only generates
    assign g_elem[0] = cin;
    assign p_elem[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bits
        assign g_elem[i+1] = a[i] & b[i];
        assign p_elem[i+1] = a[i] | b[i];
    end
endmodule

// File: rtl/cla_prefix_net.sv
module cla_prefix_net
    import cla_pkg::*;
#(
    parameter int NODES = 65
) (
    input  logic [NODES-1:0] g_in,
    input  logic [NODES-1:0] p_in,
    output logic [NODES-1:0] g_out
);
    localparam int LEVELS = $clog2(NODES);

    logic [NODES-1:0] g_lvl [LEVELS+1];
    logic [NODES-1:0] p_lvl [LEVELS];

    assign g_lvl[0] = g_in;
    assign p_lvl[0] = p_in;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int SPAN = 1 << lv;
        for (genvar e = 0; e < NODES; e++) begin : g_node
            if (e >= SPAN) begin : g_merge
                gp_t m;
                assign m = gp_merge('{g: g_lvl[lv][e],      p: p_lvl[lv][e]},
                                    '{g: g_lvl[lv][e-SPAN], p: p_lvl[lv][e-SPAN]});
                assign g_lvl[lv+1][e] = m.g;
                if (lv + 1 < LEVELS) begin : g_pnext
                    assign p_lvl[lv+1][e] = m.p;
                end
            end else begin : g_pass
                assign g_lvl[lv+1][e] = g_lvl[lv][e];
                if (lv + 1 < LEVELS) begin : g_pnext
                    assign p_lvl[lv+1][e] = p_lvl[lv][e];
                end
            end
        end
    end

    assign g_out = g_lvl[LEVELS];
endmodule

// File: rtl/cla_sum_form.sv
module cla_sum_form #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH:0]   carry,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    assign sum  = a ^ b ^ carry[WIDTH-1:0];
    assign cout = carry[WIDTH];
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
    parameter int WIDTH        = 64,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NODES = WIDTH + 1;

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } result_t;

    logic [NODES-1:0] g_elem, p_elem, carry;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;
    result_t          res_d, res_q;

    cla_bit_gp #(.WIDTH(WIDTH)) u_bit_gp (
        .a      (a),
        .b      (b),
        .cin    (cin),
        .g_elem (g_elem),
        .p_elem (p_elem)
    );

    cla_prefix_net #(.NODES(NODES)) u_prefix (
        .g_in  (g_elem),
        .p_in  (p_elem),
        .g_out (carry)
    );

    cla_sum_form #(.WIDTH(WIDTH)) u_sum (
        .a     (a),
        .b     (b),
        .carry (carry),
        .sum   (sum_c),
        .cout  (cout_c)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_c;
        res_d.cout = cout_c;
    end

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = '{cout: cout_c, sum: sum_c};
    end

    assign sum  = res_q.sum;
    assign cout = res_q.cout;
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
    parameter int WIDTH        = 64,
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    // Operands aligned with the cycle whose result is on the outputs
    logic [WIDTH-1:0] al_a, al_b;
    logic             al_cin, valid;
    logic [WIDTH:0]   total;

    if (REGISTER_OUT) begin : g_align_reg
        logic [WIDTH-1:0] a_q, b_q;
        logic             cin_q, armed_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0; b_q <= '0; cin_q <= 1'b0; armed_q <= 1'b0;
            end else begin
                a_q <= a; b_q <= b; cin_q <= cin; armed_q <= 1'b1;
            end
        end
        assign al_a = a_q; assign al_b = b_q; assign al_cin = cin_q;
        assign valid = armed_q;
    end else begin : g_align_comb
        assign al_a = a; assign al_b = b; assign al_cin = cin;
        assign valid = 1'b1;
    end

    assign total = {1'b0, al_a} + {1'b0, al_b} + {{WIDTH{1'b0}}, al_cin};

    // R1
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> sum == total[WIDTH-1:0]);

    // R2
    cout_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cout == total[WIDTH]);

    // R3
    cin_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && al_a == '0 && al_b == '0 && al_cin) |-> (sum == WIDTH'(1) && !cout));

    // R4
    full_propagate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && al_b == ~al_a) |-> (sum == {WIDTH{~al_cin}} && cout == al_cin));

    // R5
    all_generate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && &al_a && &al_b && al_cin) |-> (&sum && cout));
endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0, sum8;
    logic        cin8 = 1'b0, cout8;
    logic [63:0] a64 = '0, b64 = '0, sum64;
    logic        cin64 = 1'b0, cout64;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    prefix_adder #(.WIDTH(8), .REGISTER_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8));

    prefix_adder #(.WIDTH(64), .REGISTER_OUT(1'b0)) dut_w (
        .clk(clk), .rst_n(rst_n), .a(a64), .b(b64), .cin(cin64), .sum(sum64), .cout(cout64));

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive64(input string req, input logic [63:0] x, input logic [63:0] y,
                           input logic c);
        logic [64:0] exp;
        a64 = x; b64 = y; cin64 = c;
        #1;
        exp = {1'b0, x} + {1'b0, y} + {64'd0, c};
        check(req, {cout64, sum64}, exp);
    endtask

    initial begin
        // R7: reset holds zero outputs with nonzero operands
        a8 = 8'hff; b8 = 8'h01; cin8 = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", {56'd0, cout8, sum8}, 65'd0);
        a8 = '0; b8 = '0; cin8 = 1'b0;
        rst_n = 1'b1;

        // R6: one register stage of latency
        @(negedge clk);
        a8 = 8'd3; b8 = 8'd4; cin8 = 1'b0;
        #1;
        check("R6", {56'd0, cout8, sum8}, 65'd0);
        @(negedge clk);
        check("R6", {56'd0, cout8, sum8}, 65'd7);

        // R1 R2: every 8-bit operand pair with both carry-in values
        begin
            logic [8:0] pend;
            bit         have;
            have = 1'b0;
            pend = '0;
            for (int ci = 0; ci < 2; ci++) begin
                for (int ia = 0; ia < 256; ia++) begin
                    for (int ib = 0; ib < 256; ib++) begin
                        @(negedge clk);
                        if (have) begin
                            check("R1", {57'd0, sum8}, {57'd0, pend[7:0]});
                            check("R2", {64'd0, cout8}, {64'd0, pend[8]});
                        end
                        a8 = 8'(ia); b8 = 8'(ib); cin8 = ci[0];
                        pend = 9'(ia) + 9'(ib) + 9'(ci);
                        have = 1'b1;
                    end
                end
            end
            @(negedge clk);
            check("R1", {57'd0, sum8}, {57'd0, pend[7:0]});
            check("R2", {64'd0, cout8}, {64'd0, pend[8]});
        end

        // 64-bit corner cases on the combinational instance
        drive64("R3", 64'd0, 64'd0, 1'b1);
        drive64("R4", 64'd0, ~64'd0, 1'b0);
        drive64("R4", 64'd0, ~64'd0, 1'b1);
        drive64("R4", 64'hA5A5_0F0F_3C3C_FF00, ~64'hA5A5_0F0F_3C3C_FF00, 1'b1);
        drive64("R4", 64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b0);
        drive64("R5", ~64'd0, ~64'd0, 1'b1);
        drive64("R2", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            drive64((n % 2 == 0) ? "R1" : "R2", {$urandom, $urandom}, {$urandom, $urandom},
                    1'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog (R6) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule